// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. The array is built from rows of bitwise adder cells. Each of the first N rows adds one ANDed partial product, the multiplicand gated by a single multiplier bit, into a running sum and carry pair. The remaining carries are not finished by a ripple adder. Instead, N-1 further half-adder rows move each carry up by one bit position per row, so every row has the depth of a single full adder.

In pipelined mode a register bank follows every row. The operands travel through the pipeline together with their partial sum, so a new multiplication can start on every clock. In combinational mode all of these registers are removed: the same adder rows produce the product in the same cycle, and the valid flag passes straight through. A valid flag sent in next to the operands comes out beside the matching product.

Top module: `pipe_array_mul`

## Requirements
- R1: When valid_o is high, prod_o equals the unsigned product of the operand pair that was accepted with the matching valid_i, with all 2N bits kept.
- R2: In pipelined mode (MODE = ARR_PIPE) an operand pair presented at a rising clock edge produces its result exactly 2N-1 rising edges later, one edge per adder row.
- R3: In pipelined mode one operand pair can be accepted on every clock. Back-to-back pairs each produce a correct result, in the order they were accepted, with no cycle lost between them.
- R4: valid_o is valid_i delayed by the latency. A cycle in which valid_i is low never produces a high valid_o.
- R5: While rst_ni is low, valid_o is low in pipelined mode, whatever was in flight. After reset is released, valid_o stays low until a newly accepted pair reaches the output.
- R6: In combinational mode (MODE = ARR_COMB) the block holds no state: valid_o equals valid_i, and prod_o equals a_i times b_i in the same cycle.
- R7: A zero operand on either side gives a zero product. Two all-ones operands give (2^N-1)^2, the largest value, with no bit lost at the top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair on a_i and b_i is valid |
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| valid_o | output | 1 | prod_o holds a result |
| prod_o | output | 2N | Unsigned product |

## Verification
A stuck or dropped carry in any row corrupts the product of the first operand pair whose bits exercise that cell. This shows up 2N-1 cycles after that pair enters, as a wrong prod_o beside a high valid_o. A skew fault, where a row picks up a multiplier bit from a neighbouring sample, only shows in back-to-back traffic with differing operands. For that reason the random stream runs without gaps. A broken valid chain shows as a result at the wrong cycle, or as a valid_o with no pending pair, within one latency window.

// File: rtl/pipe_array_mul_pkg.sv
package pipe_array_mul_pkg;

  typedef enum logic {
    ARR_COMB = 1'b0,
    ARR_PIPE = 1'b1
  } arr_mode_e;

  // partial-product rows plus carry-resolution rows
  function automatic int unsigned arr_rows(input int unsigned n);
    return 2 * n - 1;
  endfunction

endpackage

// File: rtl/pam_pp_row.sv
// One partial-product row: adds (a & b_bit) << IDX into the carry-save pair.
module pam_pp_row #(
  parameter int unsigned N   = 8,
  parameter int unsigned IDX = 0,
  localparam int unsigned W  = 2 * N
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] cry_i,
  input  logic [N-1:0] a_i,
  input  logic         b_bit_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  logic [W-1:0] pp;
  logic [W-1:0] maj;

  always_comb begin
    pp    = ({{N{1'b0}}, a_i} & {W{b_bit_i}}) << IDX;
    sum_o = sum_i ^ cry_i ^ pp;
    maj   = (sum_i & cry_i) | (sum_i & pp) | (cry_i & pp);
    cry_o = maj << 1;
  end

endmodule

// File: rtl/pam_res_row.sv
// One carry-resolution row: half adders move every carry up one position.
module pam_res_row #(
  parameter int unsigned N  = 8,
  localparam int unsigned W = 2 * N
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] cry_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  always_comb begin
    sum_o = sum_i ^ cry_i;
    cry_o = (sum_i & cry_i) << 1;
  end

endmodule

// File: rtl/pipe_array_mul.sv
module pipe_array_mul
  import pipe_array_mul_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter arr_mode_e   MODE = ARR_PIPE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  output logic             valid_o,
  output logic [2*N-1:0]   prod_o
);

  localparam int unsigned W    = 2 * N;
  localparam int unsigned ROWS = arr_rows(N);

  logic [W-1:0] sum_x [ROWS+1];
  logic [W-1:0] cry_x [ROWS+1];
  logic         vld_x [ROWS+1];
  logic [N-1:0] a_x   [N];
  logic [N-1:0] b_x   [N];  // b_x[k][0] is multiplier bit k of the sample at row k

  assign sum_x[0] = '0;
  assign cry_x[0] = '0;
  assign vld_x[0] = valid_i;
  assign a_x[0]   = a_i;
  assign b_x[0]   = b_i;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    logic [W-1:0] sum_d;
    logic [W-1:0] cry_d;

    if (k < N) begin : g_pp
      pam_pp_row #(.N(N), .IDX(k)) u_pp (
        .sum_i   (sum_x[k]),
        .cry_i   (cry_x[k]),
        .a_i     (a_x[k]),
        .b_bit_i (b_x[k][0]),
        .sum_o   (sum_d),
        .cry_o   (cry_d)
      );

      // operand skew: carry this sample's operands alongside its partial sum
      if (k + 1 < N) begin : g_skew
        if (MODE == ARR_PIPE) begin : g_ff
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
              a_x[k+1] <= '0;
              b_x[k+1] <= '0;
            end else begin
              a_x[k+1] <= a_x[k];
              b_x[k+1] <= b_x[k] >> 1;
            end
          end
        end else begin : g_wire
          assign a_x[k+1] = a_x[k];
          assign b_x[k+1] = b_x[k] >> 1;
        end
      end
    end else begin : g_res
      pam_res_row #(.N(N)) u_res (
        .sum_i (sum_x[k]),
        .cry_i (cry_x[k]),
        .sum_o (sum_d),
        .cry_o (cry_d)
      );
    end

    if (MODE == ARR_PIPE) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sum_x[k+1] <= '0;
          cry_x[k+1] <= '0;
          vld_x[k+1] <= 1'b0;
        end else begin
          sum_x[k+1] <= sum_d;
          cry_x[k+1] <= cry_d;
          vld_x[k+1] <= vld_x[k];
        end
      end
    end else begin : g_wire
      assign sum_x[k+1] = sum_d;
      assign cry_x[k+1] = cry_d;
      assign vld_x[k+1] = vld_x[k];
    end
  end

  // after the last row only bit W-1 of the carry can be set; no further carry out
  assign prod_o  = sum_x[ROWS] ^ cry_x[ROWS];
  assign valid_o = vld_x[ROWS];

endmodule

// File: rtl/pipe_array_mul_chk.sv
module pipe_array_mul_chk
  import pipe_array_mul_pkg::*;
#(
  parameter int unsigned N    = 8,
  parameter arr_mode_e   MODE = ARR_PIPE
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic           valid_o,
  input logic [2*N-1:0] prod_o
);

  localparam int unsigned W   = 2 * N;
  localparam int unsigned LAT = arr_rows(N);

  logic [W-1:0] mul_now;
  assign mul_now = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};

  if (MODE == ARR_PIPE) begin : g_pipe
    logic [W-1:0] ref_p [LAT];
    logic         ref_v [LAT];
    logic         ref_z [LAT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < LAT; i++) begin
          ref_p[i] <= '0;
          ref_v[i] <= 1'b0;
          ref_z[i] <= 1'b0;
        end
      end else begin
        ref_p[0] <= mul_now;
        ref_v[0] <= valid_i;
        ref_z[0] <= (a_i == '0) || (b_i == '0);
        for (int i = 1; i < LAT; i++) begin
          ref_p[i] <= ref_p[i-1];
          ref_v[i] <= ref_v[i-1];
          ref_z[i] <= ref_z[i-1];
        end
      end
    end

    a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> prod_o == ref_p[LAT-1]);

    a_r4_valid_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == ref_v[LAT-1]);

    a_r5_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> !valid_o);

    a_r7_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && ref_z[LAT-1]) |-> prod_o == '0);
  end else begin : g_comb
    a_r6_comb_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |-> prod_o == mul_now);

    a_r6_comb_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);

    a_r7_comb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (a_i == '0 || b_i == '0)) |-> prod_o == '0);

    a_r1_comb_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && a_i == '1 && b_i == '1) |-> prod_o == mul_now);
  end

endmodule

bind pipe_array_mul pipe_array_mul_chk #(.N(N), .MODE(MODE)) u_chk (.*);

// File: tb/tb_pipe_array_mul.sv
`timescale 1ns/1ps
module tb_pipe_array_mul;
  import pipe_array_mul_pkg::*;

  localparam int unsigned N   = 8;
  localparam int unsigned W   = 2 * N;
  localparam int unsigned LAT = 2 * N - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic         valid_o, valid_c;
  logic [W-1:0] prod_o, prod_c;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  pipe_array_mul #(.N(N), .MODE(ARR_PIPE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .prod_o(prod_o));

  pipe_array_mul #(.N(N), .MODE(ARR_COMB)) dut_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_c), .prod_o(prod_c));

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < N; i++)
      if (b[i]) acc = acc + ({{N{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input bit v);
    @(negedge clk);
    a_i = a; b_i = b; valid_i = v;
    if (v) exp_q.push_back(ref_mul(a, b));
    #1;
    check(valid_c == v, "R6 comb valid", 64'(valid_c), 64'(v));
    if (v) check(prod_c == ref_mul(a, b), "R6 comb product", 64'(prod_c), 64'(ref_mul(a, b)));
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected valid_o", 64'(prod_o), 64'(0));
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(prod_o == e, "R1 R3 product", 64'(prod_o), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int first;
    // R5: reset state
    #1;
    check(valid_o == 1'b0, "R5 valid_o in reset", 64'(valid_o), 64'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4: idle cycles give no valid
    for (int i = 0; i < 20; i++) begin
      drive('0, '0, 1'b0);
      check(valid_o == 1'b0, "R4 idle valid_o", 64'(valid_o), 64'(0));
    end

    // R2: latency of a single pair
    drive(8'd13, 8'd11, 1'b1);
    first = -1;
    for (int i = 1; i <= int'(LAT) + 3; i++) begin
      drive('0, '0, 1'b0);
      if (valid_o && first < 0) first = i;
    end
    check(first == int'(LAT), "R2 latency", 64'(first), 64'(LAT));

    // R7: corner operands, back to back
    drive('0, 8'hA5, 1'b1);
    drive(8'h5A, '0, 1'b1);
    drive('1, '1, 1'b1);
    drive(8'd1, '1, 1'b1);
    drive('1, 8'd1, 1'b1);
    drive(8'h80, 8'h80, 1'b1);
    drive('0, '0, 1'b1);
    repeat (LAT + 2) drive('0, '0, 1'b0);
    check(exp_q.size() == 0, "R7 corner results drained", 64'(exp_q.size()), 64'(0));

    // R3: random back-to-back stream, then with bubbles (R4)
    for (int i = 0; i < 300; i++)
      drive(N'($urandom), N'($urandom), 1'b1);
    for (int i = 0; i < 300; i++)
      drive(N'($urandom), N'($urandom), ($urandom % 3) != 0);
    repeat (LAT + 2) drive('0, '0, 1'b0);
    check(exp_q.size() == 0, "R3 every pair returned", 64'(exp_q.size()), 64'(0));

    // R5: reset while the pipeline is full
    for (int i = 0; i < 6; i++)
      drive(N'($urandom), N'($urandom), 1'b1);
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check(valid_o == 1'b0, "R5 valid_o after mid reset", 64'(valid_o), 64'(0));
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < int'(LAT) + 5; i++) begin
      drive('0, '0, 1'b0);
      check(valid_o == 1'b0, "R5 no stale result", 64'(valid_o), 64'(0));
    end
    drive('1, '1, 1'b1);
    repeat (LAT + 2) drive('0, '0, 1'b0);
    check(exp_q.size() == 0, "R7 all-ones after reset", 64'(exp_q.size()), 64'(0));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule